// File: doc/BRIEF.md
# Flow Tuple Hash Generator

This block turns the header fields of a network flow into an index into a flow table of power-of-two depth. Each request carries a packet-type code and a packed tuple of 32-bit words that hold MAC addresses, IPv4 or IPv6 addresses and the L4 port word. The block picks three 32-bit seed words according to the packet type and mixes them into an even table index. It also gives the bucket number shared by each even/odd pair of entries.

A request is presented with `valid_i`, and the result appears one clock later with `valid_o`. A packet type that the hash does not cover raises `err_o` and returns the all-ones index mask. Upstream logic streams one request per cycle. Downstream logic uses the index to read the table and the bucket number to read the list of software flows attached to that pair.

Top module: `flow_hash_gen`

## Requirements
- R1: Type codes on `type_i`: 0 = IPv4 NAPT, 1 = IPv4 routed, 2 = bridged L2, 4 = IPv6 3-tuple, 5 = IPv6 5-tuple. Codes 3, 6 and 7 are unsupported: `err_o` is 1 and `index_o` is DEPTH-1. For supported codes `err_o` is 0.
- R2: Tuple word k is `tuple_i[32*k+31:32*k]`. For bridged flows, word 0 is the upper 32 bits of the source MAC, word 1 holds the lower 16 bits of the source MAC, word 2 is the upper 32 bits of the destination MAC and word 3 holds its lower 16 bits. The seeds are a = w1 ^ (w0[15:0] << 16), b = (w0 >> 16) ^ w3, and c = w2.
- R3: For both IPv4 types, word 0 is the source IP, word 1 is the destination IP and word 2 is the port word. The seeds are a = w2, b = w1 and c = w0.
- R4: For both IPv6 types, words 0..3 are the source address, words 4..7 are the destination address (index 0 first in each) and word 8 is the port word. The seeds are a = s3^d3^ports, b = s2^d2^d0 and c = s1^d1^s0.
- R5: Mixing: m = (a & b) | (~a & c). m is rotated left by 8 within 32 bits and then XORed with a, b and c. That value is XORed with itself shifted right by 16, shifted left by 1 and masked with DEPTH-1.
- R6: For supported types, bit 0 of `index_o` is always 0.
- R7: `bucket_o` always equals `index_o` shifted right by one.
- R8: `valid_o` is `valid_i` delayed by exactly one clock. The result for a request is shown in the cycle where `valid_o` rises or stays high, and back-to-back requests yield back-to-back results.
- R9: While `rst_ni` is low, `valid_o`, `err_o`, `index_o` and `bucket_o` are all 0.
- R10: A cycle with `valid_i` low leaves `index_o`, `bucket_o` and `err_o` unchanged, whatever `type_i` and `tuple_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| type_i | input | 3 | Packet-type code |
| tuple_i | input | 288 | Nine packed 32-bit tuple words |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| index_o | output | IDX_W (14) | Table index |
| bucket_o | output | IDX_W-1 (13) | Bucket number of the even/odd entry pair |
| err_o | output | 1 | Unsupported packet type |

## Verification
In every cycle of a back-to-back stream, the output register shows the result of the previous request while the seed selection and mixing already handle the next one. An error result and a hash result can also follow each other on consecutive cycles. The bench provokes this with an unbroken run of requests that mixes all packet types, unsupported codes included, and checks each output cycle against a model of the request from the cycle before. A model mistake or a stale capture would show up as a mismatch on the cycle where the type changes.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned TUPLE_WORDS = 9;
  localparam int unsigned TUPLE_W     = WORD_W * TUPLE_WORDS;
  localparam int unsigned TYPE_W      = 3;

  typedef enum logic [TYPE_W-1:0] {
    PT_V4_NAPT  = 3'd0,
    PT_V4_ROUTE = 3'd1,
    PT_L2_BRIDGE = 3'd2,
    PT_V4_TUNNEL = 3'd3,
    PT_V6_3T    = 3'd4,
    PT_V6_5T    = 3'd5,
    PT_RSV6     = 3'd6,
    PT_V6_TUNNEL = 3'd7
  } pkt_type_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_L2   = 2'd1,
    SC_V4   = 2'd2,
    SC_V6   = 2'd3
  } seed_class_e;

  typedef logic [TUPLE_WORDS-1:0][WORD_W-1:0] tuple_words_t;

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
  } seeds_t;

  function automatic seed_class_e class_of(input logic [TYPE_W-1:0] t);
    case (t)
      PT_V4_NAPT, PT_V4_ROUTE: return SC_V4;
      PT_L2_BRIDGE:            return SC_L2;
      PT_V6_3T, PT_V6_5T:      return SC_V6;
      default:                 return SC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/flow_seed_sel.sv
module flow_seed_sel
  import flow_hash_pkg::*;
(
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [TUPLE_W-1:0] tuple_i,
  output seeds_t             seeds_o,
  output logic               supported_o
);
  tuple_words_t w;
  seeds_t       s_l2, s_v4, s_v6;
  seed_class_e  cls;

  assign w   = tuple_i;
  assign cls = class_of(type_i);

  // bridged: fold the two MAC addresses into three words
  always_comb begin
    s_l2.a = w[1] ^ {w[0][15:0], 16'h0000};
    s_l2.b = {16'h0000, w[0][31:16]} ^ w[3];
    s_l2.c = w[2];
  end

  always_comb begin
    s_v4.a = w[2];
    s_v4.b = w[1];
    s_v4.c = w[0];
  end

  // ipv6: src words 0..3, dst words 4..7, ports word 8
  always_comb begin
    s_v6.a = w[3] ^ w[7] ^ w[8];
    s_v6.b = w[2] ^ w[6] ^ w[4];
    s_v6.c = w[1] ^ w[5] ^ w[0];
  end

  always_comb begin
    unique case (cls)
      SC_L2:   seeds_o = s_l2;
      SC_V4:   seeds_o = s_v4;
      SC_V6:   seeds_o = s_v6;
      default: seeds_o = '0;
    endcase
    supported_o = (cls != SC_NONE);
  end
endmodule

// File: rtl/flow_hash_mix.sv
module flow_hash_mix
  import flow_hash_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input  seeds_t           seeds_i,
  output logic [IDX_W-1:0] index_o
);
  localparam int unsigned ROT = 8;
  localparam int unsigned FOLD = WORD_W / 2;

  logic [WORD_W-1:0] choose, rotated, mixed, folded;
  logic [WORD_W:0]   shifted;

  always_comb begin
    choose  = (seeds_i.a & seeds_i.b) | (~seeds_i.a & seeds_i.c);
    rotated = {choose[WORD_W-ROT-1:0], choose[WORD_W-1:WORD_W-ROT]};
    mixed   = rotated ^ seeds_i.a ^ seeds_i.b ^ seeds_i.c;
    folded  = mixed ^ (mixed >> FOLD);
    shifted = {folded, 1'b0};
  end

  generate
    if (IDX_W <= WORD_W + 1) begin : g_fit
      assign index_o = shifted[IDX_W-1:0];
    end else begin : g_wide
      assign index_o = {{(IDX_W-WORD_W-1){1'b0}}, shifted};
    end
  endgenerate
endmodule

// File: rtl/flow_hash_gen.sv
module flow_hash_gen
  import flow_hash_pkg::*;
#(
  parameter int unsigned DEPTH = 16384,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [TYPE_W-1:0]   type_i,
  input  logic [TUPLE_W-1:0]  tuple_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    index_o,
  output logic [IDX_W-2:0]    bucket_o,
  output logic                err_o
);
  localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(DEPTH - 1);

  seeds_t           seeds;
  logic             supported;
  logic [IDX_W-1:0] hash_idx, next_idx;

  flow_seed_sel u_seed (
    .type_i      (type_i),
    .tuple_i     (tuple_i),
    .seeds_o     (seeds),
    .supported_o (supported)
  );

  flow_hash_mix #(.IDX_W(IDX_W)) u_mix (
    .seeds_i (seeds),
    .index_o (hash_idx)
  );

  assign next_idx = supported ? hash_idx : IDX_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      index_o <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        index_o <= next_idx;
        err_o   <= ~supported;
      end
    end
  end

  assign bucket_o = index_o[IDX_W-1:1];
endmodule

// File: rtl/flow_hash_chk.sv
module flow_hash_chk
  import flow_hash_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [TYPE_W-1:0]  type_i,
  input logic               valid_o,
  input logic [IDX_W-1:0]   index_o,
  input logic [IDX_W-2:0]   bucket_o,
  input logic               err_o
);
  p_err_type_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (err_o == (class_of($past(type_i)) == SC_NONE)));

  p_err_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (&index_o));

  p_even_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (index_o[0] == 1'b0));

  p_bucket_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bucket_o == index_o[IDX_W-1:1]);

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(index_o) && $stable(err_o)));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r9: assert (!valid_o && !err_o && index_o == '0);
    end
  end
endmodule

bind flow_hash_gen flow_hash_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .type_i   (type_i),
  .valid_o  (valid_o),
  .index_o  (index_o),
  .bucket_o (bucket_o),
  .err_o    (err_o)
);

// File: tb/flow_hash_gen_test.sv
module flow_hash_gen_test;
  localparam int DEPTH = 16384;
  localparam int IW    = 14;
  localparam int TW    = 288;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    type_i = '0;
  logic [TW-1:0] tuple_i = '0;
  logic          valid_o, err_o;
  logic [IW-1:0] index_o;
  logic [IW-2:0] bucket_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  flow_hash_gen #(.DEPTH(DEPTH)) uut (
    .clk_i, .rst_ni, .valid_i, .type_i, .tuple_i,
    .valid_o, .index_o, .bucket_o, .err_o
  );

  // independent model: returns {err, index}
  function automatic logic [IW:0] model(input logic [2:0] t, input logic [TW-1:0] tp);
    logic [31:0] w [9];
    logic [31:0] a, b, c, m;
    logic [32:0] h;
    for (int k = 0; k < 9; k++) w[k] = tp[32*k +: 32];
    case (t)
      3'd2: begin
        a = w[1] ^ (w[0] << 16);
        b = (w[0] >> 16) ^ w[3];
        c = w[2];
      end
      3'd0, 3'd1: begin a = w[2]; b = w[1]; c = w[0]; end
      3'd4, 3'd5: begin
        a = w[3] ^ w[7] ^ w[8];
        b = w[2] ^ w[6] ^ w[4];
        c = w[1] ^ w[5] ^ w[0];
      end
      default: return {1'b1, IW'(DEPTH - 1)};
    endcase
    m = (a & b) | (~a & c);
    m = (m << 8) | (m >> 24);
    m = m ^ a ^ b ^ c;
    m = m ^ (m >> 16);
    h = {1'b0, m} << 1;
    return {1'b0, h[IW-1:0] & IW'(DEPTH - 1)};
  endfunction

  function automatic logic [TW-1:0] rnd_tuple();
    logic [TW-1:0] v;
    for (int k = 0; k < 9; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [IW+IW+1:0] act, input logic [IW+IW+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // checks {valid, err, index, bucket} against model
  task automatic check_result(input string req, input logic [2:0] t, input logic [TW-1:0] tp);
    logic [IW:0] e;
    e = model(t, tp);
    check(req, {valid_o, err_o, index_o, bucket_o},
          {1'b1, e[IW], e[IW-1:0], e[IW-1:1]});
  endtask

  task automatic one_req(input string req, input logic [2:0] t, input logic [TW-1:0] tp);
    @(negedge clk_i);
    valid_i = 1'b1; type_i = t; tuple_i = tp;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_result(req, t, tp);
  endtask

  task automatic t_reset();
    #1;
    check("R9 reset", {valid_o, err_o, index_o, bucket_o}, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after release", {valid_o, err_o, index_o, bucket_o}, '0);
  endtask

  task automatic t_bridge();
    logic [TW-1:0] tp;
    tp = '0;
    tp[31:0] = 32'h0011_2233; tp[63:32] = 32'h0000_4455;
    tp[95:64] = 32'h6677_8899; tp[127:96] = 32'h0000_aabb;
    one_req("R2 R5 bridge fixed", 3'd2, tp);
    for (int i = 0; i < 6; i++) one_req("R2 R6 R7 bridge random", 3'd2, rnd_tuple());
  endtask

  task automatic t_ipv4();
    for (int i = 0; i < 5; i++) one_req("R3 R1 ipv4 napt", 3'd0, rnd_tuple());
    for (int i = 0; i < 5; i++) one_req("R3 R1 ipv4 route", 3'd1, rnd_tuple());
  endtask

  task automatic t_ipv6();
    for (int i = 0; i < 5; i++) one_req("R4 ipv6 3t", 3'd4, rnd_tuple());
    for (int i = 0; i < 5; i++) one_req("R4 ipv6 5t", 3'd5, rnd_tuple());
  endtask

  task automatic t_unsupported();
    one_req("R1 code 3", 3'd3, rnd_tuple());
    one_req("R1 code 6", 3'd6, rnd_tuple());
    one_req("R1 code 7", 3'd7, '1);
  endtask

  task automatic t_corner();
    one_req("R5 R6 all zero", 3'd0, '0);
    one_req("R5 R6 all ones v6", 3'd5, '1);
  endtask

  task automatic t_stream();
    logic [2:0]    ts [16];
    logic [TW-1:0] tps [16];
    for (int i = 0; i < 16; i++) begin
      ts[i] = 3'(i % 8);
      tps[i] = rnd_tuple();
    end
    @(negedge clk_i);
    valid_i = 1'b1; type_i = ts[0]; tuple_i = tps[0];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      check_result("R8 stream", ts[i], tps[i]);
      if (i < 15) begin
        type_i = ts[i+1]; tuple_i = tps[i+1];
      end else begin
        valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    check("R8 valid drop", {31'(0), valid_o}, '0);
  endtask

  task automatic t_hold();
    logic [TW-1:0] tp;
    logic [IW:0]   e;
    tp = rnd_tuple();
    one_req("R10 setup", 3'd1, tp);
    e = model(3'd1, tp);
    type_i = 3'd7; tuple_i = rnd_tuple();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      type_i = 3'(i + 2); tuple_i = rnd_tuple();
      check("R10 hold", {valid_o, err_o, index_o, bucket_o},
            {1'b0, e[IW], e[IW-1:0], e[IW-1:1]});
    end
  endtask

  initial begin
    t_reset();
    t_bridge();
    t_ipv4();
    t_ipv6();
    t_unsupported();
    t_corner();
    t_stream();
    t_hold();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule